// File: doc/BRIEF.md
# Trap Entry Controller

This block decides, in a 32-bit soft processor, how control passes to a trap handler. Each cycle it looks at five requests: an external interrupt, a hardware exception, a memory-translation fault, a hardware break and a software break. It also sees the current PC, the delay-slot and immediate-prefix state, the pending branch target, the faulting address and the live machine status word. When a request is accepted it produces one registered update for the next cycle. That update holds the return-address register index and value, a new status word, writes to the syndrome, fault-address and branch-target registers, and the new PC.

The pipeline commits everything that the block marks valid on the cycle `take_trap` is high. That cycle also clears the delay-slot and prefix flags and drops any load reservation. Requests are level inputs, and a request held high is serviced again on every cycle it stays high. Status bit positions are IE=1, BIP=3, EIP=9, UM=11, UMS=12, VM=13 and VMS=14. Each saved copy sits one position above its live bit.

Top module: `trap_entry_ctrl`

## Requirements
- R1: An interrupt is accepted only when status bit IE (bit 1) is 1, EIP (bit 9) and BIP (bit 3) are both 0, `in_dslot` is 0 and `imm_pend` is 0. Otherwise it produces no trap.
- R2: Interrupt entry writes `cur_pc` to register 14, clears IE and sets the PC to `vec_base`+0x10.
- R3: Hardware-exception entry writes `cur_pc`+4 to register 17, sets EIP and sets the PC to `vec_base`+0x20. The syndrome gets `hw_cause` in bits 4:0.
- R4: Translation-fault entry writes a value to register 17 and sets the PC to `vec_base`+0x20. The value is `cur_pc` minus 8 when in a delay slot whose branch was prefixed (`br_imm`), minus 4 when in a delay slot without a prefix, minus 4 when not in a delay slot but `imm_pend` is 1, and `cur_pc` otherwise. EIP is set.
- R5: On hardware-exception and translation-fault entry the syndrome is written, and its bit 12 equals `in_dslot`. The branch-target register is written with `br_target` only when `in_dslot` is 1.
- R6: On every accepted event, status bits VMS and UMS receive the old VM and UM, and VM and UM read 0. All other bits follow the input, apart from the per-event change to IE, EIP or BIP.
- R7: A hardware break writes `cur_pc` to register 16, sets BIP and sets the PC to `vec_base`+0x18. A software break sets BIP and sets the PC to `br_target` without writing a register.
- R8: The fault syndrome bits 4:0 are 16 + 2*`flt_is_miss` + `flt_is_insn`, and bit 10 is `flt_is_store` for data accesses. The fault-address register receives `flt_addr`.
- R9: `clr_flags` and `resv_clr` are high in every cycle that `take_trap` is high.
- R10: When several requests are present, only one is serviced, in this order: hardware break, translation fault, hardware exception, software break, interrupt.
- R11: Outputs appear one clock after the request cycle. `take_trap` and all write enables are low in any cycle that follows a cycle with no accepted request. `cause` is 0 for none, 1 for interrupt, 2 for hardware exception, 3 for translation fault, 4 for hardware break and 5 for software break.
- R12: A hardware-exception request is ignored while `exc_present` is 0, and a lower-priority request is then serviced.
- R13: A translation fault while EIP is set produces no trap and sets `fatal_err`, which stays high until reset.
- R14: While `rst_n` is low, `take_trap`, `cause`, every write enable and `fatal_err` are 0 after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exc_present | input | 1 | Hardware exceptions are configured in |
| vec_base | input | 32 | Base address of the trap vectors |
| req_irq | input | 1 | External interrupt request |
| req_hwexc | input | 1 | Hardware exception request |
| hw_cause | input | 5 | Cause code for a hardware exception |
| req_tfault | input | 1 | Translation fault request |
| flt_addr | input | 32 | Faulting address |
| flt_is_miss | input | 1 | Fault was a miss (0: protection) |
| flt_is_insn | input | 1 | Fault was on an instruction fetch |
| flt_is_store | input | 1 | Faulting data access was a store |
| req_hwbrk | input | 1 | Hardware break request |
| req_swbrk | input | 1 | Software break request |
| cur_pc | input | 32 | PC of the current instruction |
| in_dslot | input | 1 | Current instruction is in a branch delay slot |
| imm_pend | input | 1 | Current instruction carries an immediate prefix |
| br_imm | input | 1 | Pending branch was itself prefixed |
| br_target | input | 32 | Pending branch target |
| status_in | input | 32 | Live machine status word |
| take_trap | output | 1 | Commit strobe for this cycle's update |
| cause | output | 3 | Serviced event code |
| rf_we | output | 1 | Return-address register write enable |
| rf_idx | output | 5 | Return-address register index |
| rf_data | output | 32 | Return address |
| pc_out | output | 32 | New PC |
| status_out | output | 32 | New status word |
| esr_we | output | 1 | Syndrome write enable |
| esr_out | output | 32 | New syndrome |
| ear_we | output | 1 | Fault-address write enable |
| ear_out | output | 32 | New fault address |
| btr_we | output | 1 | Branch-target register write enable |
| btr_out | output | 32 | New branch-target value |
| clr_flags | output | 1 | Clear delay-slot and prefix flags |
| resv_clr | output | 1 | Drop the load reservation |
| fatal_err | output | 1 | Sticky nested-fault indication |

## Verification
Any mix of the five requests can arrive in one cycle, so arbitration collides with the per-event entry work. For example, a translation fault that lands in the same cycle as an enabled interrupt must win, and it must leave IE untouched while setting EIP. Such cycles are provoked by table rows that raise two to five requests together, and also combine a hardware exception with `exc_present` low. Each row is judged on the reported cause together with the return register, PC and status word. Those outputs show that only the winning event's side effects were committed.

// File: rtl/trap_pkg.sv
// Shared constants and types for the trap entry controller.
// Assumes a 32-bit status word with the bit positions below.
package trap_pkg;
    typedef enum logic [2:0] {
        CS_NONE   = 3'd0,
        CS_IRQ    = 3'd1,
        CS_HWEXC  = 3'd2,
        CS_TFAULT = 3'd3,
        CS_HWBRK  = 3'd4,
        CS_SWBRK  = 3'd5
    } cause_e;

    // Status word bit positions; each saved copy lies one above its live bit.
    localparam int ST_IE  = 1;
    localparam int ST_BIP = 3;
    localparam int ST_EIP = 9;
    localparam int ST_UM  = 11;
    localparam int ST_UMS = ST_UM + 1;
    localparam int ST_VM  = 13;
    localparam int ST_VMS = ST_VM + 1;

    // Syndrome fields.
    localparam int SY_STORE = 10;
    localparam int SY_DSLOT = 12;
    localparam int SY_FLT_BASE = 16;

    // Vector offsets and return registers.
    localparam int OFS_IRQ = 'h10;
    localparam int OFS_BRK = 'h18;
    localparam int OFS_EXC = 'h20;
    localparam int RI_IRQ = 14;
    localparam int RI_BRK = 16;
    localparam int RI_EXC = 17;
endpackage

// File: rtl/trap_arbiter.sv
// Picks the single event to service this cycle in fixed priority order.
// Assumes request inputs are levels sampled once per cycle.
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          req_irq,
    input  logic          req_hwexc,
    input  logic          req_tfault,
    input  logic          req_hwbrk,
    input  logic          req_swbrk,
    input  logic          exc_present,
    input  logic          in_dslot,
    input  logic          imm_pend,
    input  logic [DW-1:0] status_in,
    output cause_e        sel,
    output logic          fatal_hit
);
    logic irq_ok;

    // Interrupt gate: enabled, no handler running, not mid-sequence.
    always_comb begin
        irq_ok = req_irq && status_in[ST_IE] && !status_in[ST_EIP]
              && !status_in[ST_BIP] && !in_dslot && !imm_pend;
    end

    // Priority pick; a nested fault blocks every request this cycle.
    always_comb begin
        sel       = CS_NONE;
        fatal_hit = 1'b0;
        if (req_hwbrk) begin
            sel = CS_HWBRK;
        end else if (req_tfault) begin
            if (status_in[ST_EIP]) fatal_hit = 1'b1;
            else                   sel = CS_TFAULT;
        end else if (req_hwexc && exc_present) begin
            sel = CS_HWEXC;
        end else if (req_swbrk) begin
            sel = CS_SWBRK;
        end else if (irq_ok) begin
            sel = CS_IRQ;
        end
    end
endmodule

// File: rtl/trap_target.sv
// Computes the return register, return address and new PC for an event.
// Assumes 4-byte instructions and a stable vector base.
module trap_target
    import trap_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RIW = 5
) (
    input  cause_e         sel,
    input  logic [DW-1:0]  cur_pc,
    input  logic [DW-1:0]  vec_base,
    input  logic [DW-1:0]  br_target,
    input  logic           in_dslot,
    input  logic           imm_pend,
    input  logic           br_imm,
    output logic           ret_we,
    output logic [RIW-1:0] ret_idx,
    output logic [DW-1:0]  ret_val,
    output logic [DW-1:0]  new_pc
);
    localparam int ISZ = 4;
    logic [DW-1:0] fault_back;

    // Rewind distance so a fault re-runs the branch and its prefix.
    always_comb begin
        if (in_dslot)      fault_back = br_imm ? DW'(2 * ISZ) : DW'(ISZ);
        else if (imm_pend) fault_back = DW'(ISZ);
        else               fault_back = '0;
    end

    // Per-event return register, return value and vector.
    always_comb begin
        ret_we  = 1'b0;
        ret_idx = '0;
        ret_val = cur_pc;
        new_pc  = cur_pc;
        unique case (sel)
            CS_IRQ: begin
                ret_we  = 1'b1;
                ret_idx = RIW'(RI_IRQ);
                new_pc  = vec_base + DW'(OFS_IRQ);
            end
            CS_HWEXC: begin
                ret_we  = 1'b1;
                ret_idx = RIW'(RI_EXC);
                ret_val = cur_pc + DW'(ISZ);
                new_pc  = vec_base + DW'(OFS_EXC);
            end
            CS_TFAULT: begin
                ret_we  = 1'b1;
                ret_idx = RIW'(RI_EXC);
                ret_val = cur_pc - fault_back;
                new_pc  = vec_base + DW'(OFS_EXC);
            end
            CS_HWBRK: begin
                ret_we  = 1'b1;
                ret_idx = RIW'(RI_BRK);
                new_pc  = vec_base + DW'(OFS_BRK);
            end
            CS_SWBRK: new_pc = br_target;
            default: ;
        endcase
    end
endmodule

// File: rtl/trap_syndrome.sv
// Builds the new status word and the syndrome, fault-address and
// branch-target writes. Assumes HCW is at most 10 bits.
module trap_syndrome
    import trap_pkg::*;
#(
    parameter int DW  = 32,
    parameter int HCW = 5
) (
    input  cause_e          sel,
    input  logic [DW-1:0]   status_in,
    input  logic [HCW-1:0]  hw_cause,
    input  logic            in_dslot,
    input  logic            flt_is_miss,
    input  logic            flt_is_insn,
    input  logic            flt_is_store,
    input  logic [DW-1:0]   flt_addr,
    input  logic [DW-1:0]   br_target,
    output logic [DW-1:0]   status_nx,
    output logic            esr_we,
    output logic [DW-1:0]   esr_nx,
    output logic            ear_we,
    output logic [DW-1:0]   ear_nx,
    output logic            btr_we,
    output logic [DW-1:0]   btr_nx
);
    logic is_exc;

    // Exceptions are the two events that report a syndrome.
    always_comb is_exc = (sel == CS_HWEXC) || (sel == CS_TFAULT);

    // Push mode bits into their saved copies, then apply the event's flag.
    always_comb begin
        status_nx         = status_in;
        status_nx[ST_VMS] = status_in[ST_VM];
        status_nx[ST_UMS] = status_in[ST_UM];
        status_nx[ST_VM]  = 1'b0;
        status_nx[ST_UM]  = 1'b0;
        unique case (sel)
            CS_IRQ:              status_nx[ST_IE]  = 1'b0;
            CS_HWEXC, CS_TFAULT: status_nx[ST_EIP] = 1'b1;
            CS_HWBRK, CS_SWBRK:  status_nx[ST_BIP] = 1'b1;
            default: ;
        endcase
    end

    // Syndrome code, store flag and delay-slot flag.
    always_comb begin
        esr_nx = '0;
        if (sel == CS_TFAULT) begin
            esr_nx[4:0]      = 5'(SY_FLT_BASE) | {3'b000, flt_is_miss, flt_is_insn};
            esr_nx[SY_STORE] = flt_is_store && !flt_is_insn;
        end else begin
            esr_nx[HCW-1:0]  = hw_cause;
        end
        esr_nx[SY_DSLOT] = in_dslot;
        esr_we = is_exc;
    end

    // Fault address and interrupted branch target.
    always_comb begin
        ear_we = (sel == CS_TFAULT);
        ear_nx = flt_addr;
        btr_we = is_exc && in_dslot;
        btr_nx = br_target;
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
// Top of the trap entry controller: arbitrates requests, computes the
// entry update and registers it for one-cycle commit under take_trap.
// Assumes vec_base is stable and the pipeline honours the strobe.
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RIW = 5,
    parameter int HCW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           exc_present,
    input  logic [DW-1:0]  vec_base,
    input  logic           req_irq,
    input  logic           req_hwexc,
    input  logic [HCW-1:0] hw_cause,
    input  logic           req_tfault,
    input  logic [DW-1:0]  flt_addr,
    input  logic           flt_is_miss,
    input  logic           flt_is_insn,
    input  logic           flt_is_store,
    input  logic           req_hwbrk,
    input  logic           req_swbrk,
    input  logic [DW-1:0]  cur_pc,
    input  logic           in_dslot,
    input  logic           imm_pend,
    input  logic           br_imm,
    input  logic [DW-1:0]  br_target,
    input  logic [DW-1:0]  status_in,
    output logic           take_trap,
    output logic [2:0]     cause,
    output logic           rf_we,
    output logic [RIW-1:0] rf_idx,
    output logic [DW-1:0]  rf_data,
    output logic [DW-1:0]  pc_out,
    output logic [DW-1:0]  status_out,
    output logic           esr_we,
    output logic [DW-1:0]  esr_out,
    output logic           ear_we,
    output logic [DW-1:0]  ear_out,
    output logic           btr_we,
    output logic [DW-1:0]  btr_out,
    output logic           clr_flags,
    output logic           resv_clr,
    output logic           fatal_err
);
    cause_e         sel;
    logic           fatal_hit;
    logic           ret_we;
    logic [RIW-1:0] ret_idx;
    logic [DW-1:0]  ret_val, new_pc, status_nx, esr_nx, ear_nx, btr_nx;
    logic           esr_we_nx, ear_we_nx, btr_we_nx;

    trap_arbiter #(.DW(DW)) u_arb (
        .req_irq(req_irq), .req_hwexc(req_hwexc), .req_tfault(req_tfault),
        .req_hwbrk(req_hwbrk), .req_swbrk(req_swbrk),
        .exc_present(exc_present), .in_dslot(in_dslot), .imm_pend(imm_pend),
        .status_in(status_in), .sel(sel), .fatal_hit(fatal_hit)
    );

    trap_target #(.DW(DW), .RIW(RIW)) u_tgt (
        .sel(sel), .cur_pc(cur_pc), .vec_base(vec_base), .br_target(br_target),
        .in_dslot(in_dslot), .imm_pend(imm_pend), .br_imm(br_imm),
        .ret_we(ret_we), .ret_idx(ret_idx), .ret_val(ret_val), .new_pc(new_pc)
    );

    trap_syndrome #(.DW(DW), .HCW(HCW)) u_syn (
        .sel(sel), .status_in(status_in), .hw_cause(hw_cause),
        .in_dslot(in_dslot), .flt_is_miss(flt_is_miss),
        .flt_is_insn(flt_is_insn), .flt_is_store(flt_is_store),
        .flt_addr(flt_addr), .br_target(br_target),
        .status_nx(status_nx), .esr_we(esr_we_nx), .esr_nx(esr_nx),
        .ear_we(ear_we_nx), .ear_nx(ear_nx), .btr_we(btr_we_nx), .btr_nx(btr_nx)
    );

    // Register the whole entry update so it commits on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_trap  <= 1'b0;
            cause      <= CS_NONE;
            rf_we      <= 1'b0;
            esr_we     <= 1'b0;
            ear_we     <= 1'b0;
            btr_we     <= 1'b0;
            clr_flags  <= 1'b0;
            resv_clr   <= 1'b0;
            fatal_err  <= 1'b0;
            rf_idx     <= '0;
            rf_data    <= '0;
            pc_out     <= '0;
            status_out <= '0;
            esr_out    <= '0;
            ear_out    <= '0;
            btr_out    <= '0;
        end else begin
            take_trap  <= (sel != CS_NONE);
            cause      <= sel;
            rf_we      <= ret_we;
            esr_we     <= esr_we_nx;
            ear_we     <= ear_we_nx;
            btr_we     <= btr_we_nx;
            clr_flags  <= (sel != CS_NONE);
            resv_clr   <= (sel != CS_NONE);
            fatal_err  <= fatal_err || fatal_hit;
            rf_idx     <= ret_idx;
            rf_data    <= ret_val;
            pc_out     <= new_pc;
            status_out <= status_nx;
            esr_out    <= esr_nx;
            ear_out    <= ear_nx;
            btr_out    <= btr_nx;
        end
    end
endmodule

// File: rtl/trap_entry_chk.sv
// Property checker for the trap entry controller, bound to every instance.
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exc_present,
    input logic          req_hwbrk,
    input logic          req_tfault,
    input logic          in_dslot,
    input logic          imm_pend,
    input logic [DW-1:0] status_in,
    input logic          take_trap,
    input logic [2:0]    cause,
    input logic          rf_we,
    input logic          esr_we,
    input logic          ear_we,
    input logic          btr_we,
    input logic [DW-1:0] status_out,
    input logic          fatal_err
);
    p_irq_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && cause == 3'(CS_IRQ)) |->
        ($past(status_in[ST_IE]) && !$past(status_in[ST_EIP]) &&
         !$past(status_in[ST_BIP]) && !$past(in_dslot) && !$past(imm_pend)));

    p_btr_dslot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        btr_we |-> ($past(in_dslot) &&
                    (cause == 3'(CS_HWEXC) || cause == 3'(CS_TFAULT))));

    p_mode_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |-> (status_out[ST_VMS] == $past(status_in[ST_VM]) &&
                       status_out[ST_UMS] == $past(status_in[ST_UM]) &&
                       !status_out[ST_VM] && !status_out[ST_UM]));

    p_irq_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && cause == 3'(CS_IRQ)) |->
        (!$past(req_hwbrk) && !$past(req_tfault)));

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !take_trap |-> !(rf_we || esr_we || ear_we || btr_we));

    p_exc_cfg_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && cause == 3'(CS_HWEXC)) |-> $past(exc_present));

    p_fatal_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |=> fatal_err);
endmodule

bind trap_entry_ctrl trap_entry_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .exc_present(exc_present),
    .req_hwbrk(req_hwbrk), .req_tfault(req_tfault),
    .in_dslot(in_dslot), .imm_pend(imm_pend), .status_in(status_in),
    .take_trap(take_trap), .cause(cause), .rf_we(rf_we),
    .esr_we(esr_we), .ear_we(ear_we), .btr_we(btr_we),
    .status_out(status_out), .fatal_err(fatal_err)
);

// File: tb/sim_trap_entry_ctrl.sv
`timescale 1ns/1ps
module sim_trap_entry_ctrl;
    localparam logic [31:0] VEC = 32'h8000_0000;
    localparam logic [31:0] PC  = 32'h0000_1000;
    localparam logic [31:0] BT  = 32'h2000_0040;
    localparam logic [31:0] FA  = 32'hDEAD_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic exc_present, req_irq, req_hwexc, req_tfault, req_hwbrk, req_swbrk;
    logic flt_is_miss, flt_is_insn, flt_is_store, in_dslot, imm_pend, br_imm;
    logic [4:0]  hw_cause;
    logic [31:0] vec_base, flt_addr, cur_pc, br_target, status_in;
    logic take_trap, rf_we, esr_we, ear_we, btr_we, clr_flags, resv_clr, fatal_err;
    logic [2:0]  cause;
    logic [4:0]  rf_idx;
    logic [31:0] rf_data, pc_out, status_out, esr_out, ear_out, btr_out;

    trap_entry_ctrl u0 (.*);

    int checks = 0;
    int fails  = 0;

    // req bits: [4] hwbrk, [3] tfault, [2] hwexc, [1] swbrk, [0] irq
    typedef struct packed {
        logic [4:0]  req;
        logic        ds, im, bi;
        logic [15:0] st;
        logic        xp, miss, insn, store;
        logic [2:0]  ecause;
        logic [4:0]  eidx;
        logic [31:0] eret;
        logic [31:0] epc;
        logic [15:0] eesr;
        logic [15:0] est;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{5'b00001,1'b0,1'b0,1'b0,16'h2802,1'b0,1'b0,1'b0,1'b0,3'd1,5'd14,32'h1000,32'h8000_0010,16'h0000,16'h5000},
        '{5'b00001,1'b1,1'b0,1'b0,16'h0002,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,32'h0,32'h0,16'h0,16'h0},
        '{5'b00001,1'b0,1'b0,1'b0,16'h0202,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,32'h0,32'h0,16'h0,16'h0},
        '{5'b00001,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,32'h0,32'h0,16'h0,16'h0},
        '{5'b00001,1'b0,1'b1,1'b0,16'h0002,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,32'h0,32'h0,16'h0,16'h0},
        '{5'b00001,1'b0,1'b0,1'b0,16'h000A,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,32'h0,32'h0,16'h0,16'h0},
        '{5'b00100,1'b0,1'b0,1'b0,16'h0800,1'b1,1'b0,1'b0,1'b0,3'd2,5'd17,32'h1004,32'h8000_0020,16'h0003,16'h1200},
        '{5'b00100,1'b1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,3'd2,5'd17,32'h1004,32'h8000_0020,16'h1003,16'h0200},
        '{5'b00100,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,32'h0,32'h0,16'h0,16'h0},
        '{5'b01000,1'b0,1'b0,1'b0,16'h2000,1'b0,1'b0,1'b0,1'b0,3'd3,5'd17,32'h1000,32'h8000_0020,16'h0010,16'h4200},
        '{5'b01000,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b1,1'b0,3'd3,5'd17,32'h0FFC,32'h8000_0020,16'h1011,16'h0200},
        '{5'b01000,1'b1,1'b0,1'b1,16'h0000,1'b0,1'b1,1'b0,1'b1,3'd3,5'd17,32'h0FF8,32'h8000_0020,16'h1412,16'h0200},
        '{5'b01000,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b1,1'b1,1'b0,3'd3,5'd17,32'h0FFC,32'h8000_0020,16'h0013,16'h0200},
        '{5'b01000,1'b0,1'b1,1'b1,16'h0000,1'b0,1'b1,1'b0,1'b0,3'd3,5'd17,32'h0FFC,32'h8000_0020,16'h0012,16'h0200},
        '{5'b10000,1'b0,1'b0,1'b0,16'h2802,1'b0,1'b0,1'b0,1'b0,3'd4,5'd16,32'h1000,32'h8000_0018,16'h0,16'h500A},
        '{5'b00010,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,3'd5,5'd0,32'h0,32'h2000_0040,16'h0,16'h0008},
        '{5'b11111,1'b0,1'b0,1'b0,16'h0002,1'b1,1'b0,1'b0,1'b0,3'd4,5'd16,32'h1000,32'h8000_0018,16'h0,16'h000A},
        '{5'b01101,1'b0,1'b0,1'b0,16'h0002,1'b1,1'b0,1'b0,1'b0,3'd3,5'd17,32'h1000,32'h8000_0020,16'h0010,16'h0202},
        '{5'b00111,1'b0,1'b0,1'b0,16'h0002,1'b1,1'b0,1'b0,1'b0,3'd2,5'd17,32'h1004,32'h8000_0020,16'h0003,16'h0202},
        '{5'b00011,1'b0,1'b0,1'b0,16'h0002,1'b0,1'b0,1'b0,1'b0,3'd5,5'd0,32'h0,32'h2000_0040,16'h0,16'h000A},
        '{5'b00101,1'b0,1'b0,1'b0,16'h0002,1'b0,1'b0,1'b0,1'b0,3'd1,5'd14,32'h1000,32'h8000_0010,16'h0,16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4/R8";
            default: return "R7";
        endcase
    endfunction

    task automatic idle_inputs();
        {req_irq, req_hwexc, req_tfault, req_hwbrk, req_swbrk} = '0;
        {in_dslot, imm_pend, br_imm, flt_is_miss, flt_is_insn, flt_is_store} = '0;
        status_in = '0;
        exc_present = 1'b1;
    endtask

    task automatic run_vec(input vec_t v);
        logic exc;
        @(negedge clk);
        {req_hwbrk, req_tfault, req_hwexc, req_swbrk, req_irq} = v.req;
        in_dslot = v.ds; imm_pend = v.im; br_imm = v.bi;
        status_in = {16'h0, v.st}; exc_present = v.xp;
        flt_is_miss = v.miss; flt_is_insn = v.insn; flt_is_store = v.store;
        @(negedge clk);
        exc = (v.ecause == 3'd2) || (v.ecause == 3'd3);
        chk("R11 take_trap", 32'(take_trap), 32'(v.ecause != 3'd0));
        chk("R1/R10/R12 cause", 32'(cause), 32'(v.ecause));
        if (v.ecause != 3'd0) begin
            chk({tag_of(v.ecause), " rf_we"}, 32'(rf_we), 32'(v.ecause != 3'd5));
            if (v.ecause != 3'd5) begin
                chk({tag_of(v.ecause), " rf_idx"}, 32'(rf_idx), 32'(v.eidx));
                chk({tag_of(v.ecause), " rf_data"}, rf_data, v.eret);
            end
            chk({tag_of(v.ecause), " pc_out"}, pc_out, v.epc);
            chk("R6 status_out", status_out, {16'h0, v.est});
            chk("R5 esr_we", 32'(esr_we), 32'(exc));
            if (exc) chk("R5/R8 esr_out", esr_out, {16'h0, v.eesr});
            chk("R8 ear_we", 32'(ear_we), 32'(v.ecause == 3'd3));
            if (v.ecause == 3'd3) chk("R8 ear_out", ear_out, FA);
            chk("R5 btr_we", 32'(btr_we), 32'(exc && v.ds));
            if (exc && v.ds) chk("R5 btr_out", btr_out, BT);
            chk("R9 clr_flags", 32'(clr_flags), 32'd1);
            chk("R9 resv_clr", 32'(resv_clr), 32'd1);
        end
        chk("R13 fatal_err low", 32'(fatal_err), 32'd0);
        idle_inputs();
        @(negedge clk);
        chk("R11 idle take_trap", 32'(take_trap), 32'd0);
        chk("R11 idle enables", 32'({rf_we, esr_we, ear_we, btr_we}), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R11 act=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        vec_base = VEC; cur_pc = PC; br_target = BT; flt_addr = FA; hw_cause = 5'h03;
        idle_inputs();
        // R14: requests asserted during reset must not produce a trap.
        req_irq = 1'b1; status_in = 32'h2; req_hwbrk = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R14 reset take_trap", 32'(take_trap), 32'd0);
        chk("R14 reset cause", 32'(cause), 32'd0);
        chk("R14 reset enables", 32'({rf_we, esr_we, ear_we, btr_we, clr_flags, resv_clr}), 32'd0);
        chk("R14 reset fatal_err", 32'(fatal_err), 32'd0);
        idle_inputs();
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(TBL[i]);

        // R13: translation fault while already in a handler.
        @(negedge clk);
        req_tfault = 1'b1; req_irq = 1'b1; status_in = 32'h0000_0202;
        @(negedge clk);
        chk("R13 nested fault no trap", 32'(take_trap), 32'd0);
        chk("R13 fatal_err set", 32'(fatal_err), 32'd1);
        idle_inputs();
        repeat (2) @(negedge clk);
        chk("R13 fatal_err sticky", 32'(fatal_err), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R14 reset clears fatal_err", 32'(fatal_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule